// File: doc/BRIEF.md
# Floating-Point Adder/Subtractor

A purely combinational arithmetic unit that adds or subtracts two floating-point operands and returns a normalized result in the same frame in the same evaluation. Each value has three parts: a sign flag where 1 marks a positive number and 0 a negative one, an unsigned fractional mantissa read as 0.xxxx (no hidden leading one), and an exponent stored with an offset of 2^(EW-1). For the default widths, stored 64 stands for 2^0, 74 for 2^10 and 54 for 2^-10.

The unit picks the operand with the larger stored exponent. Operand A wins a tie. The other mantissa is shifted right by the exponent gap, and the bits that fall off are dropped. The two signs and the operation select decide whether the aligned mantissas are summed or subtracted. A negative difference is turned back into a magnitude and the sign flips. The result is then renormalized so that its top mantissa bit is 1. No rounding is done: every discarded bit is truncated.

A surrounding datapath drives both operands and the operation select and reads the result in the same evaluation. Mantissa width and exponent width are parameters, with defaults of 8 and 7.

Top module: `fp_addsub_unit`

## Requirements
- R1: With `op_add`=1 the result is the sum A+B. Sign 1 means positive. The mantissa value is mant/2^MW. The exponent value is exp-2^(EW-1). For example, A = (1, 0xC0, 0x41) = 0.75×2^1 plus B = (1, 0xA0, 0x3F) = 0.625×2^-1 gives (1, 0xE8, 0x41).
- R2: With `op_add`=0 the result is A-B, which is the same as adding B with its sign inverted. For example, (1,0xC0,0x41)-(1,0xA0,0x3F) gives (1,0x98,0x41), and (1,0x80,0x40)-(0,0x80,0x40) gives (1,0x80,0x41).
- R3: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are truncated. For example, a gap of 7 turns 0xFF into 0x01.
- R4: If the exponent difference is MW or more, the smaller operand contributes nothing. A normalized larger operand then passes through unchanged. For example, (0,0x80,89)+(1,0x80,68) gives (0,0x80,89).
- R5: A carry out of the mantissa sum shifts the sum right one place, puts the carry into the MSB and raises the exponent by one. For example, (1,0x80,0x40)+(1,0x80,0x40) gives (1,0x80,0x41).
- R6: When the subtracted aligned mantissa is larger, the result magnitude is the absolute difference and the result sign is the inverse of the larger-exponent operand's effective sign.
- R7: A non-zero result is shifted left until its mantissa MSB is 1, and the exponent drops by the same count. For example, (1,0x4E,45)+(1,0x58,44) gives (1,0xF4,44).
- R8: A zero mantissa result is output as mantissa 0, exponent 0, sign 1.
- R9: If the exponent would rise above the all-ones code, the output saturates to mantissa all ones and exponent all ones, and the sign of the true result is kept.
- R10: If normalization needs a shift larger than the exponent, the result is flushed to zero in the R8 form. A shift exactly equal to the exponent gives exponent 0.
- R11: If the operands have opposite effective signs and the larger-exponent operand has the larger magnitude, the output takes that operand's sign. For example, (0,0xD3,76)+(1,0x41,75) gives (0,0xB3,76).
- R12: If B has the larger exponent, B is the reference, A is the operand that is shifted, and the output exponent follows B's exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_sign | input | 1 | Sign of operand A (1 = positive) |
| a_mant | input | MW | Fractional mantissa of A |
| a_exp | input | EW | Offset-coded exponent of A |
| b_sign | input | 1 | Sign of operand B (1 = positive) |
| b_mant | input | MW | Fractional mantissa of B |
| b_exp | input | EW | Offset-coded exponent of B |
| op_add | input | 1 | 1 = A+B, 0 = A-B |
| r_sign | output | 1 | Sign of the result (1 = positive) |
| r_mant | output | MW | Normalized result mantissa |
| r_exp | output | EW | Offset-coded result exponent |

## Verification
Operand pairs with the same sign and the same exponent separate the carry path from the plain sum. Pairs with the same sign and different exponents exercise alignment and left normalization. Pairs with opposite signs and equal exponents force a negative raw difference, which shows whether the inversion and sign flip are correct. Gaps of 7 and 8 bracket the edge where the smaller operand stops contributing, and swapping which operand has the larger exponent shows whether the reference choice follows the exponents. Top-exponent sums and tiny results near exponent 0 probe saturation, flush-to-zero, and the limit where the normalization shift exactly equals the exponent.

// File: rtl/fpas_pkg.sv
// Shared definitions for the floating-point adder/subtractor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fpas_pkg;

    // Effective unsigned mantissa operation chosen by the sign logic.
    typedef enum logic {
        EFF_ADD = 1'b0,
        EFF_SUB = 1'b1
    } eff_op_e;

    // Pick the effective operation from the two effective signs.
    function automatic eff_op_e pick_op(input logic s_big, input logic s_small);
        return (s_big == s_small) ? EFF_ADD : EFF_SUB;
    endfunction

endpackage

// File: rtl/fpas_align.sv
// Alignment stage: chooses the operand with the larger exponent as the
// reference (operand A on a tie) and right-shifts the other mantissa by
// the exponent gap through a log-depth barrel shifter. A gap of MW or more
// zeroes the shifted mantissa. Bits shifted out are dropped.
// Assumes: MW >= 2, B's sign already adjusted for the requested operation.
module fpas_align #(
    parameter int MW = 8,
    parameter int EW = 7
) (
    input  logic          a_s,
    input  logic [MW-1:0] a_m,
    input  logic [EW-1:0] a_e,
    input  logic          b_s,
    input  logic [MW-1:0] b_m,
    input  logic [EW-1:0] b_e,
    output logic          big_s,
    output logic [MW-1:0] big_m,
    output logic [EW-1:0] big_e,
    output logic          sml_s,
    output logic [MW-1:0] sml_m
);
    localparam int SHW = (MW > 1) ? $clog2(MW) : 1;

    logic          a_wins;
    logic [EW-1:0] gap;
    logic [MW-1:0] raw_m;
    logic          too_far;
    logic [MW-1:0] stage [0:SHW];

    // Reference selection and exponent gap.
    always_comb begin
        a_wins = (a_e >= b_e);
        big_s  = a_wins ? a_s : b_s;
        big_m  = a_wins ? a_m : b_m;
        big_e  = a_wins ? a_e : b_e;
        sml_s  = a_wins ? b_s : a_s;
        raw_m  = a_wins ? b_m : a_m;
        gap    = a_wins ? (a_e - b_e) : (b_e - a_e);
    end

    // Detect a gap that pushes every bit out of the mantissa.
    always_comb begin
        too_far = (32'(gap) >= 32'(MW));
    end

    assign stage[0] = raw_m;

    genvar g;
    generate
        for (g = 0; g < SHW; g++) begin : g_shift
            if (g < EW) begin : g_used
                assign stage[g+1] = gap[g] ? (stage[g] >> (1 << g)) : stage[g];
            end else begin : g_pass
                assign stage[g+1] = stage[g];
            end
        end
    endgenerate

    // Final aligned mantissa of the smaller-exponent operand.
    always_comb begin
        sml_m = too_far ? '0 : stage[SHW];
    end

endmodule

// File: rtl/fpas_mag_unit.sv
// Unsigned mantissa add/subtract with conditional inversion. The sum
// returns its carry. A negative difference is negated back to a
// magnitude and reported so the caller can flip the sign.
// Assumes: both mantissas already aligned to the same exponent.
module fpas_mag_unit
    import fpas_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic          [MW-1:0] big_m,
    input  logic          [MW-1:0] sml_m,
    input  eff_op_e                op,
    output logic          [MW-1:0] mag,
    output logic                   carry,
    output logic                   neg
);
    logic [MW:0] sum_w;
    logic [MW:0] dif_w;

    // Both candidate raw results, one bit wider than the mantissa.
    always_comb begin
        sum_w = {1'b0, big_m} + {1'b0, sml_m};
        dif_w = {1'b0, big_m} - {1'b0, sml_m};
    end

    // Select the effective operation and restore a magnitude.
    always_comb begin
        if (op == EFF_ADD) begin
            mag   = sum_w[MW-1:0];
            carry = sum_w[MW];
            neg   = 1'b0;
        end else begin
            carry = 1'b0;
            neg   = dif_w[MW];
            mag   = dif_w[MW] ? (~dif_w[MW-1:0] + 1'b1) : dif_w[MW-1:0];
        end
    end

endmodule

// File: rtl/fpas_normalize.sv
// Post-normalizer. A carry shifts the sum right one place and raises the
// exponent, saturating at the all-ones code. Otherwise the leading
// zeros are counted and shifted out, and the exponent drops by that count. A zero
// magnitude or an exponent underflow gives the canonical zero
// (mantissa 0, exponent 0, positive sign).
// Assumes: MW >= 2; the input magnitude holds no sign.
module fpas_normalize #(
    parameter int MW = 8,
    parameter int EW = 7
) (
    input  logic          s_in,
    input  logic [MW-1:0] mag,
    input  logic          carry,
    input  logic [EW-1:0] e_in,
    output logic          s_out,
    output logic [MW-1:0] m_out,
    output logic [EW-1:0] e_out
);
    localparam int LZW = $clog2(MW + 1);
    localparam int CW  = ((LZW > EW) ? LZW : EW) + 1;

    logic [LZW-1:0] lz;
    logic [MW-1:0]  lsh [0:LZW];
    logic [CW-1:0]  e_wide;
    logic [CW-1:0]  lz_wide;
    logic           e_top;
    logic           under;

    // Leading-zero count: the highest set bit wins.
    always_comb begin
        lz = LZW'(MW);
        for (int i = 0; i < MW; i++) begin
            if (mag[i]) begin
                lz = LZW'(MW - 1 - i);
            end
        end
    end

    assign lsh[0] = mag;

    genvar g;
    generate
        for (g = 0; g < LZW; g++) begin : g_lshift
            assign lsh[g+1] = lz[g] ? (lsh[g] << (1 << g)) : lsh[g];
        end
    endgenerate

    // Exponent bookkeeping in a width that holds both operands.
    always_comb begin
        e_wide  = CW'(e_in);
        lz_wide = CW'(lz);
        e_top   = (e_in == {EW{1'b1}});
        under   = (lz_wide > e_wide);
    end

    // Result selection: carry path, zero, underflow, or left shift.
    always_comb begin
        s_out = s_in;
        m_out = lsh[LZW];
        e_out = EW'(e_wide - lz_wide);
        if (carry) begin
            if (e_top) begin
                m_out = {MW{1'b1}};
                e_out = {EW{1'b1}};
            end else begin
                m_out = {1'b1, mag[MW-1:1]};
                e_out = e_in + 1'b1;
            end
        end else if (mag == '0 || under) begin
            s_out = 1'b1;
            m_out = '0;
            e_out = '0;
        end
    end

endmodule

// File: rtl/fp_addsub_unit.sv
// Combinational floating-point adder/subtractor. Operands use a sign bit
// (1 = positive), a fractional mantissa with no hidden one and an
// exponent offset by 2^(EW-1). The unit aligns, adds or subtracts,
// fixes the sign and post-normalizes. There is no rounding.
// Assumes: MW >= 2, EW >= 2; inputs are held stable while the result is used.
module fp_addsub_unit
    import fpas_pkg::*;
#(
    parameter int MW = 8,
    parameter int EW = 7
) (
    input  logic          a_sign,
    input  logic [MW-1:0] a_mant,
    input  logic [EW-1:0] a_exp,
    input  logic          b_sign,
    input  logic [MW-1:0] b_mant,
    input  logic [EW-1:0] b_exp,
    input  logic          op_add,
    output logic          r_sign,
    output logic [MW-1:0] r_mant,
    output logic [EW-1:0] r_exp
);
    logic          b_sign_eff;
    logic          big_s;
    logic [MW-1:0] big_m;
    logic [EW-1:0] big_e;
    logic          sml_s;
    logic [MW-1:0] sml_m;
    eff_op_e       op;
    logic [MW-1:0] mag;
    logic          carry;
    logic          neg;
    logic          s_pre;

    // Subtraction is addition with B's sign inverted.
    always_comb begin
        b_sign_eff = op_add ? b_sign : ~b_sign;
    end

    fpas_align #(.MW(MW), .EW(EW)) align_i (
        .a_s   (a_sign),
        .a_m   (a_mant),
        .a_e   (a_exp),
        .b_s   (b_sign_eff),
        .b_m   (b_mant),
        .b_e   (b_exp),
        .big_s (big_s),
        .big_m (big_m),
        .big_e (big_e),
        .sml_s (sml_s),
        .sml_m (sml_m)
    );

    // Sign decision: the effective operation and the pre-normalization sign.
    always_comb begin
        op    = pick_op(big_s, sml_s);
        s_pre = neg ? ~big_s : big_s;
    end

    fpas_mag_unit #(.MW(MW)) mag_i (
        .big_m (big_m),
        .sml_m (sml_m),
        .op    (op),
        .mag   (mag),
        .carry (carry),
        .neg   (neg)
    );

    fpas_normalize #(.MW(MW), .EW(EW)) norm_i (
        .s_in  (s_pre),
        .mag   (mag),
        .carry (carry),
        .e_in  (big_e),
        .s_out (r_sign),
        .m_out (r_mant),
        .e_out (r_exp)
    );

endmodule

// File: rtl/fp_addsub_unit_chk.sv
// Property checker for fp_addsub_unit, bound to every instance. The unit
// has no clock, so the checks are immediate assertions on settled values.
// Assumes: the bound instance uses the same MW and EW.
module fp_addsub_unit_chk #(
    parameter int MW = 8,
    parameter int EW = 7
) (
    input logic          a_sign,
    input logic [MW-1:0] a_mant,
    input logic [EW-1:0] a_exp,
    input logic          b_sign,
    input logic [MW-1:0] b_mant,
    input logic [EW-1:0] b_exp,
    input logic          op_add,
    input logic          r_sign,
    input logic [MW-1:0] r_mant,
    input logic [EW-1:0] r_exp
);
    logic [EW:0] e_max;

    // Largest input exponent, widened by one bit for the carry case.
    always_comb begin
        e_max = (a_exp >= b_exp) ? {1'b0, a_exp} : {1'b0, b_exp};
    end

    // Output relations checked whenever the inputs change.
    always_comb begin
        // R7: a non-zero result is always normalized
        a_r7_normalized: assert (r_mant == '0 || r_mant[MW-1])
            else $error("r_mant not normalized");
        // R8: zero is canonical
        a_r8_zero_form: assert (r_mant != '0 || (r_exp == '0 && r_sign))
            else $error("zero result not canonical");
        // R5: the exponent rises by at most one above the larger input
        a_r5_exp_bound: assert (r_mant == '0 || {1'b0, r_exp} <= e_max + 1'b1)
            else $error("result exponent out of range");
        // R4: a far-away smaller B leaves a normalized A unchanged
        a_r4_insignificant: assert (!(a_exp > b_exp && 32'(a_exp - b_exp) > 32'(MW) && a_mant[MW-1])
                                    || (r_sign == a_sign && r_mant == a_mant && r_exp == a_exp))
            else $error("insignificant operand changed the result");
        // R1: a true sum of like signs keeps that sign
        a_r1_like_sign: assert (!(op_add && a_sign == b_sign && r_mant != '0) || r_sign == a_sign)
            else $error("sign of a like-sign sum changed");
    end

endmodule

bind fp_addsub_unit fp_addsub_unit_chk #(.MW(MW), .EW(EW)) chk_i (
    .a_sign (a_sign),
    .a_mant (a_mant),
    .a_exp  (a_exp),
    .b_sign (b_sign),
    .b_mant (b_mant),
    .b_exp  (b_exp),
    .op_add (op_add),
    .r_sign (r_sign),
    .r_mant (r_mant),
    .r_exp  (r_exp)
);

// File: tb/fp_addsub_unit_tb_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// checks of the all-zero start state and extra corner cases.
module fp_addsub_unit_tb_top;
    localparam int MW = 8;
    localparam int EW = 7;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_sign = 1'b0;
    logic [MW-1:0] a_mant = '0;
    logic [EW-1:0] a_exp = '0;
    logic          b_sign = 1'b0;
    logic [MW-1:0] b_mant = '0;
    logic [EW-1:0] b_exp = '0;
    logic          op_add = 1'b0;
    logic          r_sign;
    logic [MW-1:0] r_mant;
    logic [EW-1:0] r_exp;

    int n_checks = 0;
    int n_fail   = 0;
    logic done   = 1'b0;

    always #2.5 clk = ~clk;

    fp_addsub_unit #(.MW(MW), .EW(EW)) dut_i (
        .a_sign (a_sign), .a_mant (a_mant), .a_exp (a_exp),
        .b_sign (b_sign), .b_mant (b_mant), .b_exp (b_exp),
        .op_add (op_add),
        .r_sign (r_sign), .r_mant (r_mant), .r_exp (r_exp)
    );

    // Vector layout: tag, sa, ma, ea, sb, mb, eb, op, exp s, exp m, exp e
    localparam logic [56:0] TBL [0:NV-1] = '{
        {8'd1,  1'b1,8'hC0,7'h41, 1'b1,8'hA0,7'h3F, 1'b1, 1'b1,8'hE8,7'h41}, // R1
        {8'd2,  1'b1,8'hC0,7'h41, 1'b1,8'hA0,7'h3F, 1'b0, 1'b1,8'h98,7'h41}, // R2
        {8'd2,  1'b1,8'h80,7'h40, 1'b0,8'h80,7'h40, 1'b0, 1'b1,8'h80,7'h41}, // R2
        {8'd11, 1'b0,8'hD3,7'd76, 1'b1,8'h41,7'd75, 1'b1, 1'b0,8'hB3,7'd76}, // R11
        {8'd3,  1'b1,8'h80,7'h47, 1'b1,8'hFF,7'h40, 1'b1, 1'b1,8'h81,7'h47}, // R3
        {8'd4,  1'b0,8'h80,7'd89, 1'b1,8'h80,7'd68, 1'b1, 1'b0,8'h80,7'd89}, // R4
        {8'd4,  1'b1,8'h80,7'h48, 1'b1,8'hFF,7'h40, 1'b1, 1'b1,8'h80,7'h48}, // R4
        {8'd5,  1'b1,8'h80,7'h40, 1'b1,8'h80,7'h40, 1'b1, 1'b1,8'h80,7'h41}, // R5
        {8'd5,  1'b1,8'hC0,7'h40, 1'b1,8'hC0,7'h40, 1'b1, 1'b1,8'hC0,7'h41}, // R5
        {8'd6,  1'b1,8'h80,7'h40, 1'b1,8'hC0,7'h40, 1'b0, 1'b0,8'h80,7'h3F}, // R6
        {8'd7,  1'b1,8'h4E,7'd45, 1'b1,8'h58,7'd44, 1'b1, 1'b1,8'hF4,7'd44}, // R7
        {8'd8,  1'b1,8'hA5,7'h50, 1'b1,8'hA5,7'h50, 1'b0, 1'b1,8'h00,7'h00}, // R8
        {8'd8,  1'b0,8'hA5,7'h50, 1'b1,8'hA5,7'h50, 1'b1, 1'b1,8'h00,7'h00}, // R8
        {8'd9,  1'b1,8'h80,7'h7F, 1'b1,8'h80,7'h7F, 1'b1, 1'b1,8'hFF,7'h7F}, // R9
        {8'd9,  1'b0,8'hC0,7'h7F, 1'b0,8'h80,7'h7F, 1'b1, 1'b0,8'hFF,7'h7F}, // R9
        {8'd9,  1'b1,8'h80,7'h7E, 1'b1,8'h80,7'h7E, 1'b1, 1'b1,8'h80,7'h7F}, // R9
        {8'd10, 1'b1,8'h01,7'h03, 1'b1,8'h00,7'h00, 1'b1, 1'b1,8'h00,7'h00}, // R10
        {8'd10, 1'b1,8'h01,7'h07, 1'b1,8'h00,7'h00, 1'b1, 1'b1,8'h80,7'h00}, // R10
        {8'd12, 1'b1,8'h80,7'h40, 1'b1,8'h80,7'h42, 1'b1, 1'b1,8'hA0,7'h42}, // R12
        {8'd12, 1'b1,8'h80,7'h40, 1'b1,8'h80,7'h42, 1'b0, 1'b0,8'hC0,7'h41}  // R12
    };

    // Compare the settled outputs with one expected triple.
    task automatic check(input int tag, input logic es, input logic [MW-1:0] em,
                         input logic [EW-1:0] ee);
        n_checks++;
        if (r_sign !== es || r_mant !== em || r_exp !== ee) begin
            n_fail++;
            $display("FAIL R%0d: got s=%0b m=%h e=%h, expected s=%0b m=%h e=%h",
                     tag, r_sign, r_mant, r_exp, es, em, ee);
        end
    endtask

    // Drive one operand set after a rising edge and sample at the falling edge.
    task automatic apply(input logic sa, input logic [MW-1:0] ma, input logic [EW-1:0] ea,
                         input logic sb, input logic [MW-1:0] mb, input logic [EW-1:0] eb,
                         input logic op);
        @(posedge clk);
        #1;
        a_sign = sa; a_mant = ma; a_exp = ea;
        b_sign = sb; b_mant = mb; b_exp = eb;
        op_add = op;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Main stimulus: start state, table walk, then directed corners.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(8, 1'b1, 8'h00, 7'h00); // R8: all-zero start inputs give canonical zero

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i][48], TBL[i][47:40], TBL[i][39:33],
                  TBL[i][32], TBL[i][31:24], TBL[i][23:17], TBL[i][16]);
            check(int'(TBL[i][56:49]), TBL[i][15], TBL[i][14:7], TBL[i][6:0]);
        end

        // R3: gap of 1 truncates the shifted-out bit: 0x80 + (0x81>>1=0x40) = 0xC0
        apply(1'b1, 8'h80, 7'h41, 1'b1, 8'h81, 7'h40, 1'b1);
        check(3, 1'b1, 8'hC0, 7'h41);
        // R4: B larger by 9 makes A vanish; subtract inverts B's sign
        apply(1'b1, 8'h80, 7'h30, 1'b1, 8'h90, 7'h39, 1'b0);
        check(4, 1'b0, 8'h90, 7'h39);
        // R6: like-exponent negatives, smaller A magnitude: -0.5 + +0.75 = +0.25
        apply(1'b0, 8'h80, 7'h40, 1'b1, 8'hC0, 7'h40, 1'b1);
        check(6, 1'b1, 8'h80, 7'h3F);
        // R10: flush when the shift exceeds the exponent by one
        apply(1'b0, 8'h02, 7'h05, 1'b0, 8'h00, 7'h00, 1'b1);
        check(10, 1'b1, 8'h00, 7'h00);
        // R8: both mantissas zero
        apply(1'b0, 8'h00, 7'h22, 1'b1, 8'h00, 7'h11, 1'b0);
        check(8, 1'b1, 8'h00, 7'h00);

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

endmodule